// File: doc/BRIEF.md
# Register Rename Map with Free-Register Counter

This block keeps, for each architectural register, the tag of the in-flight instruction that will produce its value. The tag is that instruction's sequence number, and a ready bit beside it says whether the result already exists. A rename port accepts one instruction per cycle with up to two sources and one destination. In the same cycle the block returns each source's producer tag and ready state, reports the destination's previous mapping so it can be kept for recovery, and says whether the instruction can issue at once. On the next clock edge the destination entry takes the new tag, marked not ready.

A writeback port broadcasts a finished tag and sets the ready bit of every entry holding that tag. A restore port replaces the whole map in one cycle with a committed copy, which is how a squash is recovered. A signed counter tracks how many physical registers remain free. Each destination rename lowers it by one. A free port adds to it, up to the physical register total. While the counter is zero or negative, a blocked output tells the producer of renames to hold off.

Top module: `rename_map_table`

## Requirements
- R1: After reset every map entry holds tag 0 with ready set, the free counter equals NUM_PHYS, and rename_blocked_o is low.
- R2: For each valid source, src*_tag_o and src*_rdy_o combinationally show the current entry of that register. An invalid source reports ready 1.
- R3: issue_ok_o is high exactly when every valid source is ready. With no valid source it is high.
- R4: prev_tag_o/prev_rdy_o show the destination's current entry. After the edge on which a destination rename is accepted, that entry holds {ready=0, tag=new_tag_i}.
- R5: A source naming the same register as the destination of the same instruction reports the mapping from before that rename.
- R6: A writeback sets the ready bit of every entry whose tag equals wb_tag_i, effective at the next edge. An install to the same entry in the same cycle takes precedence and leaves it not ready.
- R7: Each accepted destination rename lowers the counter by one. The counter may go below zero.
- R8: A free request adds free_num_i to the counter, in the same cycle as any rename decrement. The result saturates at NUM_PHYS.
- R9: rename_blocked_o is high exactly while the counter is zero or below.
- R10: A restore replaces the whole map at the next edge. Entry i comes from restore_map_i[i*(TAG_W+1) +: TAG_W+1], with the ready bit at the top and the tag in the lower TAG_W bits. A restore takes precedence over rename and writeback in the same cycle, a rename dropped this way does not decrement the counter, and the counter is otherwise left as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src0_v_i | input | 1 | First source is used |
| src0_idx_i | input | IDX_W | First source register |
| src1_v_i | input | 1 | Second source is used |
| src1_idx_i | input | IDX_W | Second source register |
| dst_v_i | input | 1 | Instruction writes a destination |
| dst_idx_i | input | IDX_W | Destination register |
| new_tag_i | input | TAG_W | Sequence number of the renamed instruction |
| src0_tag_o | output | TAG_W | Producer tag of first source |
| src0_rdy_o | output | 1 | First source value available |
| src1_tag_o | output | TAG_W | Producer tag of second source |
| src1_rdy_o | output | 1 | Second source value available |
| issue_ok_o | output | 1 | All used sources are available |
| prev_tag_o | output | TAG_W | Previous producer of the destination |
| prev_rdy_o | output | 1 | Previous producer's ready bit |
| wb_v_i | input | 1 | Writeback broadcast valid |
| wb_tag_i | input | TAG_W | Tag of the finished instruction |
| restore_v_i | input | 1 | Load the whole map from restore_map_i |
| restore_map_i | input | NUM_ARCH*(TAG_W+1) | Committed map image |
| free_v_i | input | 1 | Return registers to the counter |
| free_num_i | input | CNT_W-1 | Number of registers returned |
| free_regs_o | output | CNT_W (signed) | Free physical register count |
| rename_blocked_o | output | 1 | Counter is zero or negative |

## Verification
The hardest state to reach is a counter that has gone below zero and then climbs back through zero. The stimulus first drains the counter with a long run of destination renames, then renames once more while blocked, and then frees registers one at a time so that the blocked output can be seen holding at zero and releasing at one. Collisions in the same cycle are built on purpose: a writeback against an install to the same entry, and a restore alongside both a rename and a writeback. The map image is read back through the source ports to confirm which of them took effect.

// File: rtl/rnm_pkg.sv
package rnm_pkg;
    parameter int TAG_W = 8;

    typedef struct packed {
        logic             ready;
        logic [TAG_W-1:0] tag;
    } rnm_entry_t;

    localparam int ENT_W = $bits(rnm_entry_t);
endpackage

// File: rtl/rnm_lookup.sv
module rnm_lookup
    import rnm_pkg::*;
#(
    parameter int NUM_ARCH = 16,
    localparam int IDX_W = $clog2(NUM_ARCH)
) (
    input  rnm_entry_t [NUM_ARCH-1:0] map_i,
    input  logic                      vld_i,
    input  logic [IDX_W-1:0]          idx_i,
    output logic [TAG_W-1:0]          tag_o,
    output logic                      ready_o
);
    rnm_entry_t sel;

    always_comb begin
        sel     = map_i[idx_i];
        tag_o   = sel.tag;
        ready_o = !vld_i || sel.ready;
    end
endmodule

// File: rtl/rnm_counter.sv
module rnm_counter #(
    parameter int NUM_PHYS = 32,
    localparam int CNT_W = $clog2(NUM_PHYS + 1) + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    dec_i,
    input  logic                    free_v_i,
    input  logic [CNT_W-2:0]        free_num_i,
    output logic signed [CNT_W-1:0] count_o,
    output logic                    blocked_o
);
    typedef struct packed {
        logic signed [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t state_d, state_q;
    int         sum;

    always_comb begin
        state_d = state_q;
        sum     = int'(state_q.cnt);
        if (dec_i)    sum = sum - 1;
        if (free_v_i) sum = sum + int'(free_num_i);
        if (sum > NUM_PHYS) sum = NUM_PHYS;
        state_d.cnt = CNT_W'(sum);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q.cnt <= CNT_W'(NUM_PHYS);
        else        state_q     <= state_d;
    end

    assign count_o   = state_q.cnt;
    assign blocked_o = (state_q.cnt <= 0);

    assert_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count_o) <= NUM_PHYS);

    assert_dec_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dec_i && !free_v_i |=> int'(count_o) == int'($past(count_o)) - 1);

    assert_unblock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(blocked_o) |-> $past(free_v_i));

    assert_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(blocked_o) |-> $past(dec_i));
endmodule

// File: rtl/rename_map_table.sv
module rename_map_table
    import rnm_pkg::*;
#(
    parameter int NUM_ARCH = 16,
    parameter int NUM_PHYS = 32,
    localparam int IDX_W = $clog2(NUM_ARCH),
    localparam int CNT_W = $clog2(NUM_PHYS + 1) + 1,
    localparam int NUM_SRC = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      src0_v_i,
    input  logic [IDX_W-1:0]          src0_idx_i,
    input  logic                      src1_v_i,
    input  logic [IDX_W-1:0]          src1_idx_i,
    input  logic                      dst_v_i,
    input  logic [IDX_W-1:0]          dst_idx_i,
    input  logic [TAG_W-1:0]          new_tag_i,
    output logic [TAG_W-1:0]          src0_tag_o,
    output logic                      src0_rdy_o,
    output logic [TAG_W-1:0]          src1_tag_o,
    output logic                      src1_rdy_o,
    output logic                      issue_ok_o,
    output logic [TAG_W-1:0]          prev_tag_o,
    output logic                      prev_rdy_o,
    input  logic                      wb_v_i,
    input  logic [TAG_W-1:0]          wb_tag_i,
    input  logic                      restore_v_i,
    input  logic [NUM_ARCH*ENT_W-1:0] restore_map_i,
    input  logic                      free_v_i,
    input  logic [CNT_W-2:0]          free_num_i,
    output logic signed [CNT_W-1:0]   free_regs_o,
    output logic                      rename_blocked_o
);
    typedef struct packed {
        rnm_entry_t [NUM_ARCH-1:0] map;
    } map_state_t;

    map_state_t state_d, state_q;

    logic [NUM_SRC-1:0]            src_v;
    logic [NUM_SRC-1:0][IDX_W-1:0] src_idx;
    logic [NUM_SRC-1:0][TAG_W-1:0] src_tag;
    logic [NUM_SRC-1:0]            src_rdy;
    logic                          prev_rdy_raw;
    logic                          install;

    assign src_v   = {src1_v_i, src0_v_i};
    assign src_idx = {src1_idx_i, src0_idx_i};
    assign install = dst_v_i && !restore_v_i;

    // Source reads see the registered map, so same-cycle installs are invisible (R5).
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        rnm_lookup #(.NUM_ARCH(NUM_ARCH)) i_lookup (
            .map_i   (state_q.map),
            .vld_i   (src_v[s]),
            .idx_i   (src_idx[s]),
            .tag_o   (src_tag[s]),
            .ready_o (src_rdy[s])
        );
    end

    rnm_lookup #(.NUM_ARCH(NUM_ARCH)) i_prev (
        .map_i   (state_q.map),
        .vld_i   (1'b1),
        .idx_i   (dst_idx_i),
        .tag_o   (prev_tag_o),
        .ready_o (prev_rdy_raw)
    );

    assign src0_tag_o = src_tag[0];
    assign src0_rdy_o = src_rdy[0];
    assign src1_tag_o = src_tag[1];
    assign src1_rdy_o = src_rdy[1];
    assign issue_ok_o = &src_rdy;
    assign prev_rdy_o = prev_rdy_raw;

    always_comb begin
        state_d = state_q;
        if (restore_v_i) begin
            state_d.map = restore_map_i;
        end else begin
            if (wb_v_i) begin
                for (int i = 0; i < NUM_ARCH; i++) begin
                    if (state_q.map[i].tag == wb_tag_i) state_d.map[i].ready = 1'b1;
                end
            end
            if (dst_v_i) begin
                state_d.map[dst_idx_i].tag   = new_tag_i;
                state_d.map[dst_idx_i].ready = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ARCH; i++) begin
                state_q.map[i].tag   <= '0;
                state_q.map[i].ready <= 1'b1;
            end
        end else begin
            state_q <= state_d;
        end
    end

    rnm_counter #(.NUM_PHYS(NUM_PHYS)) i_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .dec_i      (install),
        .free_v_i   (free_v_i),
        .free_num_i (free_num_i),
        .count_o    (free_regs_o),
        .blocked_o  (rename_blocked_o)
    );

    assert_install_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dst_v_i && !restore_v_i |=>
            state_q.map[$past(dst_idx_i)].tag == $past(new_tag_i) &&
            !state_q.map[$past(dst_idx_i)].ready);

    assert_restore_R10: assert property (@(posedge clk) disable iff (!rst_n)
        restore_v_i |=> state_q.map == $past(restore_map_i));

    assert_no_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !src0_v_i && !src1_v_i |-> issue_ok_o);

    for (genvar e = 0; e < NUM_ARCH; e++) begin : g_wb_chk
        assert_wb_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
            wb_v_i && !restore_v_i && !(dst_v_i && dst_idx_i == IDX_W'(e)) &&
            state_q.map[e].tag == wb_tag_i |=> state_q.map[e].ready);
    end
endmodule

// File: tb/test_rename_map_table.sv
module test_rename_map_table;
    import rnm_pkg::*;

    localparam int NA = 16;
    localparam int NP = 32;
    localparam int IW = $clog2(NA);
    localparam int CW = $clog2(NP + 1) + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic s0v = 0, s1v = 0, dv = 0, wbv = 0, rsv = 0, fv = 0;
    logic [IW-1:0] s0 = 0, s1 = 0, d = 0;
    logic [TAG_W-1:0] tg = 0, wbt = 0;
    logic [NA*ENT_W-1:0] rmap = '0;
    logic [CW-2:0] fnum = 0;
    logic [TAG_W-1:0] s0t, s1t, pt;
    logic s0r, s1r, iss, pr, blk;
    logic signed [CW-1:0] fr;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    rename_map_table #(.NUM_ARCH(NA), .NUM_PHYS(NP)) i_rename_map_table (
        .clk(clk), .rst_n(rst_n),
        .src0_v_i(s0v), .src0_idx_i(s0), .src1_v_i(s1v), .src1_idx_i(s1),
        .dst_v_i(dv), .dst_idx_i(d), .new_tag_i(tg),
        .src0_tag_o(s0t), .src0_rdy_o(s0r), .src1_tag_o(s1t), .src1_rdy_o(s1r),
        .issue_ok_o(iss), .prev_tag_o(pt), .prev_rdy_o(pr),
        .wb_v_i(wbv), .wb_tag_i(wbt), .restore_v_i(rsv), .restore_map_i(rmap),
        .free_v_i(fv), .free_num_i(fnum),
        .free_regs_o(fr), .rename_blocked_o(blk)
    );

    typedef struct packed {
        logic s0v; logic [3:0] s0; logic s1v; logic [3:0] s1;
        logic dv; logic [3:0] d; logic [7:0] tg;
        logic [7:0] e0t; logic e0r; logic [7:0] e1t; logic e1r;
        logic [7:0] ept; logic epr; logic eiss;
    } vec_t;

    // Walked from reset: every entry starts {ready=1, tag=0}.
    localparam vec_t VECS [5] = '{
        '{1'b0,4'd0, 1'b0,4'd0, 1'b1,4'd1, 8'd10,  8'd0,1'b1,  8'd0,1'b1,  8'd0,1'b1,  1'b1},
        '{1'b1,4'd1, 1'b0,4'd0, 1'b1,4'd2, 8'd11,  8'd10,1'b0, 8'd0,1'b1,  8'd0,1'b1,  1'b0},
        '{1'b1,4'd2, 1'b1,4'd1, 1'b1,4'd1, 8'd12,  8'd11,1'b0, 8'd10,1'b0, 8'd10,1'b0, 1'b0},
        '{1'b1,4'd1, 1'b1,4'd1, 1'b1,4'd1, 8'd13,  8'd12,1'b0, 8'd12,1'b0, 8'd12,1'b0, 1'b0},
        '{1'b1,4'd3, 1'b1,4'd4, 1'b0,4'd0, 8'd0,   8'd0,1'b1,  8'd0,1'b1,  8'd0,1'b1,  1'b1}
    };

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        s0v = 0; s1v = 0; dv = 0; wbv = 0; rsv = 0; fv = 0;
    endtask

    task automatic peek(input int idx, output int t, output int r);
        @(negedge clk);
        idle_inputs();
        s0v = 1; s0 = IW'(idx);
        #2;
        t = int'(s0t); r = int'(s0r);
        s0v = 0;
    endtask

    task automatic ren_dst(input int idx, input int tag);
        @(negedge clk);
        idle_inputs();
        dv = 1; d = IW'(idx); tg = TAG_W'(tag);
        @(posedge clk); #1;
        idle_inputs();
    endtask

    task automatic free_regs(input int n);
        @(negedge clk);
        idle_inputs();
        fv = 1; fnum = (CW-1)'(n);
        @(posedge clk); #1;
        idle_inputs();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int t, r;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // R1 reset state
        chk("R1 count", int'(fr), NP);
        chk("R1 blocked", int'(blk), 0);
        peek(7, t, r);
        chk("R1 tag", t, 0);
        chk("R1 ready", r, 1);

        // Table walk: R2 R3 R4 R5
        foreach (VECS[k]) begin
            @(negedge clk);
            idle_inputs();
            s0v = VECS[k].s0v; s0 = VECS[k].s0;
            s1v = VECS[k].s1v; s1 = VECS[k].s1;
            dv = VECS[k].dv; d = VECS[k].d; tg = VECS[k].tg;
            #2;
            chk("R2 src0 tag", int'(s0t), int'(VECS[k].e0t));
            chk("R2 src0 rdy", int'(s0r), int'(VECS[k].e0r));
            chk("R5 src1 tag", int'(s1t), int'(VECS[k].e1t));
            chk("R2 src1 rdy", int'(s1r), int'(VECS[k].e1r));
            chk("R4 prev tag", int'(pt), int'(VECS[k].ept));
            chk("R4 prev rdy", int'(pr), int'(VECS[k].epr));
            chk("R3 issue", int'(iss), int'(VECS[k].eiss));
            @(posedge clk); #1;
            idle_inputs();
        end
        peek(1, t, r);
        chk("R4 installed tag", t, 13);
        chk("R4 installed not ready", r, 0);
        chk("R7 count after 4 renames", int'(fr), NP - 4);

        // R6 writeback to every matching entry
        ren_dst(5, 20);
        ren_dst(6, 20);
        @(negedge clk); idle_inputs(); wbv = 1; wbt = 8'd20;
        @(posedge clk); #1; idle_inputs();
        peek(5, t, r); chk("R6 wb entry5", r, 1);
        peek(6, t, r); chk("R6 wb entry6", r, 1);
        peek(1, t, r); chk("R6 unmatched stays", r, 0);

        // R6 install beats writeback on same entry
        @(negedge clk); idle_inputs();
        dv = 1; d = 4'd7; tg = 8'd40; wbv = 1; wbt = 8'd0;
        @(posedge clk); #1; idle_inputs();
        peek(7, t, r);
        chk("R6 install wins tag", t, 40);
        chk("R6 install wins rdy", r, 0);
        chk("R7 count", int'(fr), NP - 7);

        // R8 saturation
        free_regs(10);
        chk("R8 saturate", int'(fr), NP);

        // R7 R9 drain below zero
        for (int i = 0; i < NP; i++) ren_dst(8, 50 + i);
        chk("R7 drained", int'(fr), 0);
        chk("R9 blocked at zero", int'(blk), 1);
        ren_dst(8, 99);
        chk("R7 negative", int'(fr), -1);
        chk("R9 blocked negative", int'(blk), 1);
        free_regs(1);
        chk("R9 still blocked at zero", int'(blk), 1);
        free_regs(1);
        chk("R9 released", int'(blk), 0);
        chk("R8 count one", int'(fr), 1);

        // R8 rename and free in the same cycle
        @(negedge clk); idle_inputs();
        dv = 1; d = 4'd9; tg = 8'd77; fv = 1; fnum = 3;
        @(posedge clk); #1; idle_inputs();
        chk("R8 dec plus free", int'(fr), 3);

        // R10 restore beats rename and writeback, counter untouched
        for (int i = 0; i < NA; i++)
            rmap[i*ENT_W +: ENT_W] = {i[0], TAG_W'(100 + i)};
        @(negedge clk); idle_inputs();
        rsv = 1; dv = 1; d = 4'd2; tg = 8'd99; wbv = 1; wbt = 8'd102;
        @(posedge clk); #1; idle_inputs();
        peek(2, t, r);
        chk("R10 tag2", t, 102);
        chk("R10 rdy2", r, 0);
        peek(3, t, r);
        chk("R10 tag3", t, 103);
        chk("R10 rdy3", r, 1);
        chk("R10 count kept", int'(fr), 3);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule